// File: doc/BRIEF.md
# High-Definition Output Gain and Sync Inserter

This block sits between the pixel source and the three video converters when a VGA or high-definition display is driven. It takes one unscaled pixel per pixel clock on three 10-bit channels. Channel A carries green or luma, channel B carries blue or Pb, and channel C carries red or Pr. The block hands the pixel to the converters two pixel clocks later. An RGB pixel can be turned into Y-Pb-Pr on the way. Y-Pb-Pr data can never be turned into RGB: that combination is treated as invalid, and the samples pass through untouched. Everything runs on the incoming pixel clock.

A gain select gives either the full converter swing or a swing reduced to about 0.69. In the reduced case every channel is lifted by a fixed offset, which leaves room under the video for a sync tip. While the horizontal or the vertical timing strobe is active, a small state machine replaces channel A with either a bi-level or a tri-level sync. During that time channels B and C are held at their blanking level. The state machine has four states:
- `ST_VIDEO` passes the video through.
- `ST_BI` holds the bi-level tip.
- `ST_TRI_LO` holds the low half of a tri-level pulse for a fixed number of cycles.
- `ST_TRI_HI` holds the high half until the strobe ends.

The transitions are:
- `ST_VIDEO` goes to `ST_BI` when a strobe starts and bi-level sync is enabled.
- `ST_VIDEO` goes to `ST_TRI_LO` when a strobe starts and tri-level sync is enabled.
- `ST_TRI_LO` goes to `ST_TRI_HI` once its count is reached.
- Every sync state returns to `ST_VIDEO` when the strobe ends or sync is disabled.

Top module: `hd_sync_gain_path`

## Requirements
- R1: With unity gain and no conversion, each output channel equals the matching input channel from exactly two clocks earlier, one sample per clock with no gaps.
- R2: With RGB input (`in_ypbpr_i`=0) and Y-Pb-Pr output (`out_rgb_i`=0), the outputs are computed as follows:
  - Y = (54R+183G+19B+128)>>8
  - Pb = 512 + floor((138(B−Y)+128)/256)
  - Pr = 512 + floor((163(R−Y)+128)/256)
  - Y leaves on channel A, Pb on channel B and Pr on channel C.
- R3: With Y-Pb-Pr input and RGB output selected together (invalid), all three channels pass through unconverted.
- R4: With `gain_low_i`=1, every video sample becomes 316 + ((x·177+128)>>8). With `gain_low_i`=0, samples are unchanged.
- R5: Converted Pb and Pr are clamped to the range 0..1023.
- R6: `sync_mode_i` encodes the sync type: 0 = none, 1 = bi-level, 2 = tri-level, 3 = none. While bi-level sync is active, channel A is 0 and channels B and C are at blanking.
- R7: During tri-level sync, channel A is 0 for the first TRI_LOW_LEN cycles of the strobe and 632 for the rest of it. A strobe no longer than TRI_LOW_LEN gives only the low level.
- R8: The sync strobe is the OR of `hsync_i` and `vsync_i`. Sync on the outputs starts and ends two clocks after the strobe does, so it stays aligned with the data.
- R9: With unity gain, the strobes have no effect on any output, whatever the sync mode.
- R10: While reset is asserted, all outputs are 0 and the state machine is in `ST_VIDEO`.
- R11: The blanking level of channels B and C is 316 when they carry RGB data. It is 670 when they carry colour-difference data, which is the case when the input is Y-Pb-Pr or the output is Y-Pb-Pr.
- R12: Sync mode 3 with reduced gain inserts no sync: the outputs stay on the scaled video.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Incoming pixel clock |
| rst_n | input | 1 | Active-low reset |
| pix_a_i | input | 10 | Green or Y input sample |
| pix_b_i | input | 10 | Blue or Pb input sample |
| pix_c_i | input | 10 | Red or Pr input sample |
| hsync_i | input | 1 | Horizontal sync strobe, high for the pulse |
| vsync_i | input | 1 | Vertical sync strobe, high for the pulse |
| in_ypbpr_i | input | 1 | 1 = input is Y-Pb-Pr, 0 = RGB |
| out_rgb_i | input | 1 | 1 = RGB output, 0 = Y-Pb-Pr output |
| gain_low_i | input | 1 | 1 = reduced swing with offset, 0 = full swing |
| sync_mode_i | input | 2 | Sync type, encoded as in R6 |
| dac_a_o | output | 10 | Converter sample, green or Y, carries sync |
| dac_b_o | output | 10 | Converter sample, blue or Pb |
| dac_c_o | output | 10 | Converter sample, red or Pr |

## Verification
A stuck or wrongly entered sync state appears on channel A within two clocks of the strobe edge. It shows up as a tip at 0, a 632 step in the wrong cycle, or video where a tip belongs. A miscounted tri-level low half moves the 0→632 step by one or more cycles, and a sample-exact check of every pulse cycle catches that. A wrong conversion or gain path shows up as a numeric mismatch on the next sample. The cases that separate a correct design from a wrong one are gray input (neutral chroma), saturated red and cyan (both clamps), and the full-scale and zero inputs at reduced gain (blanking and peak).

// File: rtl/hdsg_pkg.sv
package hdsg_pkg;

    // sync type selector, values fixed by the mode input encoding
    typedef enum logic [1:0] {
        SYNC_NONE = 2'd0,
        SYNC_BI   = 2'd1,
        SYNC_TRI  = 2'd2,
        SYNC_RSV  = 2'd3
    } sync_sel_e;

    typedef enum logic [1:0] {
        ST_VIDEO  = 2'd0,
        ST_BI     = 2'd1,
        ST_TRI_LO = 2'd2,
        ST_TRI_HI = 2'd3
    } ins_state_e;

    // channel positions: A = green/Y, B = blue/Pb, C = red/Pr
    localparam int CH_A = 0;
    localparam int CH_B = 1;
    localparam int CH_C = 2;
    localparam int N_CH = 3;

    // fixed-point constants, FRAC fractional bits
    localparam int FRAC     = 8;
    localparam int HALF_LSB = 1 << (FRAC - 1);
    localparam int CY_R     = 54;
    localparam int CY_G     = 183;
    localparam int CY_B     = 19;
    localparam int C_PB     = 138;
    localparam int C_PR     = 163;
    localparam int GAIN_NUM = 177;

endpackage

// File: rtl/hdsg_csc.sv
module hdsg_csc
    import hdsg_pkg::*;
#(
    parameter int PIX_W = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_ypbpr_i,
    input  logic                          out_rgb_i,
    input  logic [N_CH-1:0][PIX_W-1:0]    pix_i,
    output logic [N_CH-1:0][PIX_W-1:0]    pix_o
);

    localparam int MAXV = (1 << PIX_W) - 1;
    localparam int MID  = 1 << (PIX_W - 1);

    logic                       do_conv;
    logic [N_CH-1:0][PIX_W-1:0] conv;

    function automatic logic [PIX_W-1:0] diff_scale(
        input logic [PIX_W-1:0] col,
        input logic [PIX_W-1:0] luma,
        input int               coef
    );
        int d;
        int p;
        int c;
        d = int'(col) - int'(luma);
        p = (d * coef + HALF_LSB) >>> FRAC;
        c = p + MID;
        if (c < 0) begin
            c = 0;
        end else if (c > MAXV) begin
            c = MAXV;
        end
        return PIX_W'(c);
    endfunction

    // only RGB in with Y-Pb-Pr out is converted; the invalid pair passes
    assign do_conv = !in_ypbpr_i && !out_rgb_i;

    always_comb begin
        int ysum;
        logic [PIX_W-1:0] yv;
        ysum = CY_R * int'(pix_i[CH_C]) + CY_G * int'(pix_i[CH_A])
             + CY_B * int'(pix_i[CH_B]) + HALF_LSB;
        yv = PIX_W'(ysum >>> FRAC);
        conv[CH_A] = yv;
        conv[CH_B] = diff_scale(pix_i[CH_B], yv, C_PB);
        conv[CH_C] = diff_scale(pix_i[CH_C], yv, C_PR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_o <= '0;
        end else if (do_conv) begin
            pix_o <= conv;
        end else begin
            pix_o <= pix_i;
        end
    end

    assert_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !do_conv |=> pix_o == $past(pix_i));

    assert_gray_neutral_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (do_conv && pix_i[CH_A] == pix_i[CH_B] && pix_i[CH_A] == pix_i[CH_C])
        |=> (pix_o[CH_B] == PIX_W'(MID) && pix_o[CH_C] == PIX_W'(MID)
             && pix_o[CH_A] == $past(pix_i[CH_A])));

endmodule

// File: rtl/hdsg_gain.sv
module hdsg_gain
    import hdsg_pkg::*;
#(
    parameter int PIX_W     = 10,
    parameter int BLANK_LVL = 316
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          gain_low_i,
    input  logic [N_CH-1:0][PIX_W-1:0]    pix_i,
    output logic [N_CH-1:0][PIX_W-1:0]    pix_o
);

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic [PIX_W-1:0] scaled;

        always_comb begin
            int prod;
            prod   = int'(pix_i[c]) * GAIN_NUM + HALF_LSB;
            scaled = PIX_W'(BLANK_LVL + (prod >>> FRAC));
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pix_o[c] <= '0;
            end else begin
                pix_o[c] <= gain_low_i ? scaled : pix_i[c];
            end
        end

        assert_above_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(gain_low_i)) |-> pix_o[c] >= PIX_W'(BLANK_LVL));

        assert_unity_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !gain_low_i |=> pix_o[c] == $past(pix_i[c]));
    end

endmodule

// File: rtl/hdsg_sync_fsm.sv
module hdsg_sync_fsm
    import hdsg_pkg::*;
#(
    parameter int TRI_LOW_LEN = 44
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hsync_i,
    input  logic       vsync_i,
    input  logic       gain_low_i,
    input  logic [1:0] sync_mode_i,
    output ins_state_e state_o
);

    localparam int CW = $clog2(TRI_LOW_LEN + 1);

    ins_state_e     st_q;
    ins_state_e     st_n;
    logic [CW-1:0]  cnt_q;
    logic [CW-1:0]  cnt_n;
    logic           strobe_q;
    logic           sync_on;
    logic           is_tri;

    assign is_tri  = sync_sel_e'(sync_mode_i) == SYNC_TRI;
    assign sync_on = gain_low_i
                   && (sync_sel_e'(sync_mode_i) == SYNC_BI || is_tri);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_VIDEO;
            cnt_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            st_q     <= st_n;
            cnt_q    <= cnt_n;
            strobe_q <= hsync_i | vsync_i;
        end
    end

    // transitions
    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        unique case (st_q)
            ST_VIDEO: begin
                if (sync_on && strobe_q) begin
                    if (is_tri) begin
                        st_n  = ST_TRI_LO;
                        cnt_n = CW'(1);
                    end else begin
                        st_n = ST_BI;
                    end
                end
            end
            ST_BI: begin
                if (!strobe_q || !sync_on) begin
                    st_n = ST_VIDEO;
                end
            end
            ST_TRI_LO: begin
                if (!strobe_q || !sync_on) begin
                    st_n = ST_VIDEO;
                end else if (cnt_q == CW'(TRI_LOW_LEN)) begin
                    st_n = ST_TRI_HI;
                end else begin
                    cnt_n = cnt_q + CW'(1);
                end
            end
            ST_TRI_HI: begin
                if (!strobe_q || !sync_on) begin
                    st_n = ST_VIDEO;
                end
            end
            default: st_n = ST_VIDEO;
        endcase
    end

    assign state_o = st_q;

    assert_unity_no_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_on |=> st_q == ST_VIDEO);

    assert_tri_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TRI_HI && $past(st_q) != ST_TRI_HI) |-> $past(st_q) == ST_TRI_LO);

    assert_sync_follows_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q != ST_VIDEO |-> $past(strobe_q));

    assert_low_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_TRI_LO |-> (cnt_q >= CW'(1) && cnt_q <= CW'(TRI_LOW_LEN)));

endmodule

// File: rtl/hd_sync_gain_path.sv
module hd_sync_gain_path
    import hdsg_pkg::*;
#(
    parameter int PIX_W       = 10,
    parameter int TRI_LOW_LEN = 44
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] pix_a_i,
    input  logic [PIX_W-1:0] pix_b_i,
    input  logic [PIX_W-1:0] pix_c_i,
    input  logic             hsync_i,
    input  logic             vsync_i,
    input  logic             in_ypbpr_i,
    input  logic             out_rgb_i,
    input  logic             gain_low_i,
    input  logic [1:0]       sync_mode_i,
    output logic [PIX_W-1:0] dac_a_o,
    output logic [PIX_W-1:0] dac_b_o,
    output logic [PIX_W-1:0] dac_c_o
);

    localparam int MAXV        = (1 << PIX_W) - 1;
    localparam int MID         = 1 << (PIX_W - 1);
    localparam int SCALED_MAX  = (MAXV * GAIN_NUM + HALF_LSB) >> FRAC;
    localparam int BLANK       = MAXV - SCALED_MAX;
    localparam int CHROMA_BLK  = BLANK + ((MID * GAIN_NUM + HALF_LSB) >> FRAC);
    localparam int TRI_HIGH    = 2 * BLANK;

    logic [N_CH-1:0][PIX_W-1:0] pix_in;
    logic [N_CH-1:0][PIX_W-1:0] pix_cv;
    logic [N_CH-1:0][PIX_W-1:0] pix_gn;
    logic                       chroma_data;
    logic [PIX_W-1:0]           side_blank;
    ins_state_e                 ins_st;

    assign pix_in[CH_A] = pix_a_i;
    assign pix_in[CH_B] = pix_b_i;
    assign pix_in[CH_C] = pix_c_i;

    assign chroma_data = in_ypbpr_i || !out_rgb_i;
    assign side_blank  = chroma_data ? PIX_W'(CHROMA_BLK) : PIX_W'(BLANK);

    hdsg_csc #(.PIX_W(PIX_W)) u_csc (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_ypbpr_i (in_ypbpr_i),
        .out_rgb_i  (out_rgb_i),
        .pix_i      (pix_in),
        .pix_o      (pix_cv)
    );

    hdsg_gain #(.PIX_W(PIX_W), .BLANK_LVL(BLANK)) u_gain (
        .clk        (clk),
        .rst_n      (rst_n),
        .gain_low_i (gain_low_i),
        .pix_i      (pix_cv),
        .pix_o      (pix_gn)
    );

    hdsg_sync_fsm #(.TRI_LOW_LEN(TRI_LOW_LEN)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hsync_i     (hsync_i),
        .vsync_i     (vsync_i),
        .gain_low_i  (gain_low_i),
        .sync_mode_i (sync_mode_i),
        .state_o     (ins_st)
    );

    // outputs from state
    always_comb begin
        unique case (ins_st)
            ST_VIDEO: begin
                dac_a_o = pix_gn[CH_A];
                dac_b_o = pix_gn[CH_B];
                dac_c_o = pix_gn[CH_C];
            end
            ST_BI, ST_TRI_LO: begin
                dac_a_o = '0;
                dac_b_o = side_blank;
                dac_c_o = side_blank;
            end
            ST_TRI_HI: begin
                dac_a_o = PIX_W'(TRI_HIGH);
                dac_b_o = side_blank;
                dac_c_o = side_blank;
            end
            default: begin
                dac_a_o = pix_gn[CH_A];
                dac_b_o = pix_gn[CH_B];
                dac_c_o = pix_gn[CH_C];
            end
        endcase
    end

    assert_sync_needs_low_gain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ins_st != ST_VIDEO |-> $past(gain_low_i));

    assert_reset_zero_R10: assert property (@(posedge clk)
        !rst_n |-> (dac_a_o == '0 && dac_b_o == '0 && dac_c_o == '0));

endmodule

// File: tb/hd_sync_gain_path_bench.sv
module hd_sync_gain_path_bench;

    localparam int CLK_PERIOD = 10;
    localparam int TLEN       = 4;
    localparam int BLANK      = 316;
    localparam int CBLANK     = 670;
    localparam int THIGH      = 632;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] pa = '0, pb = '0, pc = '0;
    logic       hs = 1'b0, vs = 1'b0;
    logic       in_ypbpr = 1'b0, out_rgb = 1'b1, gain_low = 1'b0;
    logic [1:0] smode = 2'd0;
    logic [9:0] oa, ob, oc;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hd_sync_gain_path #(.PIX_W(10), .TRI_LOW_LEN(TLEN)) u_hd_sync_gain_path (
        .clk(clk), .rst_n(rst_n),
        .pix_a_i(pa), .pix_b_i(pb), .pix_c_i(pc),
        .hsync_i(hs), .vsync_i(vs),
        .in_ypbpr_i(in_ypbpr), .out_rgb_i(out_rgb), .gain_low_i(gain_low),
        .sync_mode_i(smode),
        .dac_a_o(oa), .dac_b_o(ob), .dac_c_o(oc)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int f_y(input int r, input int g, input int b);
        return (54 * r + 183 * g + 19 * b + 128) >>> 8;
    endfunction

    function automatic int f_diff(input int col, input int y, input int k);
        int v;
        v = 512 + ((k * (col - y) + 128) >>> 8);
        if (v < 0) v = 0;
        if (v > 1023) v = 1023;
        return v;
    endfunction

    function automatic int f_gain(input int x);
        return 316 + ((x * 177 + 128) >>> 8);
    endfunction

    task automatic set_mode(input logic iy, input logic orgb, input logic gl, input logic [1:0] sm);
        @(negedge clk);
        in_ypbpr = iy; out_rgb = orgb; gain_low = gl; smode = sm;
        repeat (3) @(negedge clk);
    endtask

    // drive one pixel, check it two clocks later
    task automatic pix_check(input string req, input int a, input int b, input int c,
                             input int ea, input int eb, input int ec);
        @(negedge clk);
        pa = 10'(a); pb = 10'(b); pc = 10'(c);
        repeat (2) @(negedge clk);
        chk(req, "A", int'(oa), ea);
        chk(req, "B", int'(ob), eb);
        chk(req, "C", int'(oc), ec);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R10", "A reset", int'(oa), 0);
        chk("R10", "B reset", int'(ob), 0);
        chk("R10", "C reset", int'(oc), 0);
    endtask

    task automatic t_unity_pass;
        int sa[4] = '{5, 1023, 0, 700};
        int sb[4] = '{900, 1, 512, 33};
        set_mode(1'b0, 1'b1, 1'b0, 2'd0);
        pix_check("R1", 100, 200, 300, 100, 200, 300);
        // back-to-back stream: each sample appears two clocks later
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                chk("R1", "stream A", int'(oa), sa[i-2]);
                chk("R1", "stream B", int'(ob), sb[i-2]);
            end
            if (i < 4) begin
                pa = 10'(sa[i]); pb = 10'(sb[i]); pc = 10'(i);
            end
        end
    endtask

    task automatic t_convert;
        int r, g, b, y;
        int tr[4] = '{300, 0, 1023, 0};
        int tg[4] = '{300, 0, 0, 1023};
        int tbl[4] = '{300, 1023, 0, 1023};
        set_mode(1'b0, 1'b0, 1'b0, 2'd0);
        for (int i = 0; i < 4; i++) begin
            r = tr[i]; g = tg[i]; b = tbl[i];
            y = f_y(r, g, b);
            // gray gives neutral chroma; red clamps Pr high, cyan clamps Pr low (R5)
            pix_check((i >= 2) ? "R5" : "R2", g, b, r, y, f_diff(b, y, 138), f_diff(r, y, 163));
        end
        chk("R5", "red Pr clamp", f_diff(1023, f_y(1023, 0, 0), 163), 1023);
        chk("R5", "cyan Pr clamp", f_diff(0, f_y(0, 1023, 1023), 163), 0);
    endtask

    task automatic t_invalid;
        set_mode(1'b1, 1'b1, 1'b0, 2'd0);
        pix_check("R3", 640, 12, 1000, 640, 12, 1000);
    endtask

    task automatic t_reduced;
        set_mode(1'b0, 1'b1, 1'b1, 2'd0);
        pix_check("R4", 0, 1023, 512, BLANK, f_gain(1023), f_gain(512));
        chk("R4", "peak", f_gain(1023), 1023);
    endtask

    // strobe for len cycles; checks each output cycle against the strobe two clocks earlier
    task automatic run_sync(input string req, input int len, input bit tri_m, input bit use_v,
                            input bit expect_sync, input int side, input int va, input int vb, input int vc);
        int ea;
        for (int i = 0; i < len + 4; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                if (expect_sync && (i - 2) < len) begin
                    ea = (tri_m && (i - 2) >= TLEN) ? THIGH : 0;
                    chk(req, "sync A", int'(oa), ea);
                    chk(req, "sync B", int'(ob), side);
                    chk(req, "sync C", int'(oc), side);
                end else begin
                    chk(req, "video A", int'(oa), va);
                    chk(req, "video B", int'(ob), vb);
                    chk(req, "video C", int'(oc), vc);
                end
            end
            if (use_v) vs = (i < len);
            else       hs = (i < len);
        end
        hs = 1'b0; vs = 1'b0;
    endtask

    task automatic t_bilevel;
        set_mode(1'b0, 1'b1, 1'b1, 2'd1);
        pix_check("R6", 400, 400, 400, f_gain(400), f_gain(400), f_gain(400));
        run_sync("R6", 6, 1'b0, 1'b0, 1'b1, BLANK, f_gain(400), f_gain(400), f_gain(400));
        // vertical strobe, colour-difference data: side channels blank at 670 (R8, R11)
        set_mode(1'b1, 1'b0, 1'b1, 2'd1);
        run_sync("R11", 5, 1'b0, 1'b1, 1'b1, CBLANK, f_gain(400), f_gain(400), f_gain(400));
    endtask

    task automatic t_trilevel;
        set_mode(1'b0, 1'b1, 1'b1, 2'd2);
        run_sync("R7", 9, 1'b1, 1'b0, 1'b1, BLANK, f_gain(400), f_gain(400), f_gain(400));
        run_sync("R7", 3, 1'b1, 1'b0, 1'b1, BLANK, f_gain(400), f_gain(400), f_gain(400));
        run_sync("R8", 1, 1'b1, 1'b1, 1'b1, BLANK, f_gain(400), f_gain(400), f_gain(400));
    endtask

    task automatic t_unity_sync;
        set_mode(1'b0, 1'b1, 1'b0, 2'd2);
        run_sync("R9", 7, 1'b1, 1'b0, 1'b0, 0, 400, 400, 400);
        set_mode(1'b0, 1'b1, 1'b0, 2'd1);
        run_sync("R9", 4, 1'b0, 1'b1, 1'b0, 0, 400, 400, 400);
    endtask

    task automatic t_reserved;
        set_mode(1'b0, 1'b1, 1'b1, 2'd3);
        run_sync("R12", 5, 1'b0, 1'b0, 1'b0, 0, f_gain(400), f_gain(400), f_gain(400));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_unity_pass();
        t_convert();
        t_invalid();
        t_reduced();
        t_bilevel();
        t_trilevel();
        t_unity_sync();
        t_reserved();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule